// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block sits between an interrupt message receiver and a processor core. Every request carries an 8-bit vector, a 3-bit delivery mode and a level/edge trigger flag. Fixed and lowest-priority requests are queued in a 256-bit request vector, with a matching 256-bit trigger-mode vector beside it. Vectors the core has taken are tracked in a 256-bit in-service vector. SMI, NMI, INIT, startup and external requests skip those vectors. Each of them holds its own pending flag and a latched vector.

Every cycle the block picks one interrupt to present. It weighs three things: the core's interrupt-enable flag, an 8-bit task-priority register, and the priority class (vector bits 7:4) of the highest requested vector against the highest in-service vector. An acknowledge commits the presented interrupt. An end-of-interrupt retires the highest in-service vector. A small state machine records whether the core has been started. It moves from CORE_HALTED to CORE_RUNNING when a startup is acknowledged. It moves from CORE_RUNNING to CORE_HALTED when an INIT is acknowledged.

The presentation choice is a named selection, listed from highest priority to lowest:
- SEL_SMI
- SEL_NMI
- SEL_INIT
- SEL_START
- SEL_EXT
- SEL_REG
- SEL_NONE, when nothing is presented

Top module: `vipa_arbiter`

## Requirements
- R1: A request with mode 0 (fixed) or 1 (lowest priority) sets the request bit of its vector when that bit is clear. In the same step it writes the trigger bit: 1 for a level request, 0 for an edge request. `irr_top` shows the highest set request vector. `irr_top_level` shows the trigger bit of that vector.
- R2: A mode 0/1 request for a vector whose request bit is already set changes neither the request bit nor the trigger bit.
- R3: Modes 2 (SMI), 4 (NMI) and 5 (INIT) each set their own pending flag and latch the vector, but only when that flag is clear. A repeat while the flag is pending is dropped, and the first vector is kept.
- R4: Mode 6 (startup) is accepted only when no startup is pending and the core state is CORE_HALTED. Reset puts the core in CORE_HALTED, so `core_started` is 0. Acknowledging an INIT returns the core to CORE_HALTED. Acknowledging a startup moves it to CORE_RUNNING.
- R5: Mode 7 (external) pends and latches its vector but is presented only while `intr_enable` is 1. Mode 3 requests are ignored.
- R6: Any pending SMI, NMI, INIT or startup is presented whatever `intr_enable` is. The presentation order is SMI, NMI, INIT, startup, external, regular. `irq_kind` encodes the choice as 0 none, 1 SMI, 2 NMI, 3 INIT, 4 startup, 5 external, 6 regular.
- R7: A regular interrupt is presented only when three conditions hold: `intr_enable` is 1, `irr_top` is greater than `isr_top`, and `irr_top[7:4]` is greater than `task_pri[7:4]`. `irq_vector` is then `irr_top`.
- R8: Acknowledging a regular interrupt sets its in-service bit, clears its request bit, and recomputes both highest vectors. An acknowledge while `irq_out` is 0 has no effect.
- R9: An end-of-interrupt clears the in-service bit of `isr_top`, after which `isr_top` drops to the next lower in-service vector, or to 0 if none is left.
- R10: `task_pri` resets to 0 and takes `tpr_wdata` on the cycle after `tpr_we` is high.
- R11: Vector 0 counts as "none set" for both highest-vector encoders. After reset, `irq_out`, `irq_kind`, `irr_top` and `isr_top` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_vector | input | 8 | Request vector |
| req_mode | input | 3 | Delivery mode code |
| req_level | input | 1 | 1 level, 0 edge |
| intr_enable | input | 1 | Core interrupt-enable flag |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write value |
| ack | input | 1 | Commit the presented interrupt |
| eoi | input | 1 | Retire the highest in-service vector |
| irq_out | output | 1 | An interrupt is presented |
| irq_kind | output | 3 | Selection code of the presented interrupt |
| irq_vector | output | 8 | Vector of the presented interrupt |
| core_started | output | 1 | Core state is CORE_RUNNING |
| irr_top | output | 8 | Highest set request vector |
| isr_top | output | 8 | Highest set in-service vector |
| irr_top_level | output | 1 | Trigger bit of `irr_top` |
| task_pri | output | 8 | Task-priority register |

## Verification
The assertions check, on every cycle, the gating of a presented regular interrupt by the enable flag, the in-service vector and the task-priority class. They also check that only unmaskable kinds appear while the enable flag is low, the start-state transitions on INIT and startup acknowledge, the in-service vector after an acknowledge or an end-of-interrupt, and the task-priority update. The ordering among several pending unmaskable requests, the dropping of repeated requests, the retention of the first trigger bit, and the exact vector reached after nested end-of-interrupts can only be shown by the bench's scenarios. The bench also sweeps every vector and every pair of task-priority class and vector class.

// File: rtl/vipa_pkg.sv
package vipa_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_SMI   = 3'd1,
        SEL_NMI   = 3'd2,
        SEL_INIT  = 3'd3,
        SEL_START = 3'd4,
        SEL_EXT   = 3'd5,
        SEL_REG   = 3'd6
    } sel_e;

    typedef enum logic {
        CORE_HALTED  = 1'b0,
        CORE_RUNNING = 1'b1
    } core_e;

    localparam int NUM_SPECIAL = 5;

    // Special kinds are indexed 0..4 in presentation order.
    function automatic logic [2:0] special_mode(input int k);
        case (k)
            0:       return DM_SMI;
            1:       return DM_NMI;
            2:       return DM_INIT;
            3:       return DM_START;
            default: return DM_EXT;
        endcase
    endfunction

endpackage

// File: rtl/vipa_prio_enc.sv
module vipa_prio_enc #(
    parameter int N = 256,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] bits_in,
    output logic [W-1:0] top
);

    // Highest set index wins; index 0 reports as 0 either way.
    always_comb begin
        top = '0;
        for (int i = 0; i < N; i++) begin
            if (bits_in[i]) begin
                top = W'(i);
            end
        end
    end

endmodule

// File: rtl/vipa_vec_bank.sv
module vipa_vec_bank #(
    parameter int NUM_VEC = 256,
    localparam int VW = $clog2(NUM_VEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [VW-1:0] set_vec,
    input  logic          set_level,
    input  logic          take_en,
    input  logic          eoi_en,
    output logic [VW-1:0] irr_top,
    output logic [VW-1:0] isr_top,
    output logic          irr_top_level
);

    logic [NUM_VEC-1:0] req_bits;
    logic [NUM_VEC-1:0] svc_bits;
    logic [NUM_VEC-1:0] trig_bits;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
        logic set_hit;
        logic take_hit;
        logic eoi_hit;

        assign set_hit  = set_en && (set_vec == VW'(g)) && !req_bits[g];
        assign take_hit = take_en && (irr_top == VW'(g));
        assign eoi_hit  = eoi_en && (isr_top == VW'(g)) && (g != 0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_bits[g]  <= 1'b0;
                svc_bits[g]  <= 1'b0;
                trig_bits[g] <= 1'b0;
            end else begin
                if (take_hit) begin
                    req_bits[g] <= 1'b0;
                end else if (set_hit) begin
                    req_bits[g] <= 1'b1;
                end
                if (set_hit) begin
                    trig_bits[g] <= set_level;
                end
                if (take_hit) begin
                    svc_bits[g] <= 1'b1;
                end else if (eoi_hit) begin
                    svc_bits[g] <= 1'b0;
                end
            end
        end
    end

    vipa_prio_enc #(.N(NUM_VEC)) u_irr_enc (
        .bits_in (req_bits),
        .top     (irr_top)
    );

    vipa_prio_enc #(.N(NUM_VEC)) u_isr_enc (
        .bits_in (svc_bits),
        .top     (isr_top)
    );

    assign irr_top_level = trig_bits[irr_top];

endmodule

// File: rtl/vipa_special.sv
module vipa_special
    import vipa_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [2:0]                      req_mode,
    input  logic [VW-1:0]                   req_vector,
    input  logic                            commit,
    input  sel_e                            commit_sel,
    output logic [NUM_SPECIAL-1:0]          pend,
    output logic [NUM_SPECIAL-1:0][VW-1:0]  pend_vec,
    output logic                            core_started
);

    core_e core_q;
    core_e core_d;

    // State register of the start-state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= CORE_HALTED;
        end else begin
            core_q <= core_d;
        end
    end

    // Transitions: INIT acknowledge halts, startup acknowledge runs.
    always_comb begin
        core_d = core_q;
        if (commit) begin
            unique case (commit_sel)
                SEL_INIT:  core_d = CORE_HALTED;
                SEL_START: core_d = CORE_RUNNING;
                default:   core_d = core_q;
            endcase
        end
    end

    assign core_started = (core_q == CORE_RUNNING);

    for (genvar k = 0; k < NUM_SPECIAL; k++) begin : g_kind
        logic          flag_q;
        logic [VW-1:0] vec_q;
        logic          gate;
        logic          accept;
        logic          retire;

        if (k == 3) begin : g_start_gate
            assign gate = (core_q == CORE_HALTED);
        end else begin : g_open_gate
            assign gate = 1'b1;
        end

        assign accept = req_valid && (req_mode == special_mode(k)) && !flag_q && gate;
        assign retire = commit && (commit_sel == sel_e'(k + 1));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                vec_q  <= '0;
            end else if (accept) begin
                flag_q <= 1'b1;
                vec_q  <= req_vector;
            end else if (retire) begin
                flag_q <= 1'b0;
            end
        end

        assign pend[k]     = flag_q;
        assign pend_vec[k] = vec_q;
    end

endmodule

// File: rtl/vipa_arbiter.sv
module vipa_arbiter
    import vipa_pkg::*;
#(
    parameter int NUM_VEC = 256,
    localparam int VW = $clog2(NUM_VEC),
    localparam int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [VW-1:0] req_vector,
    input  logic [2:0]    req_mode,
    input  logic          req_level,
    input  logic          intr_enable,
    input  logic          tpr_we,
    input  logic [VW-1:0] tpr_wdata,
    input  logic          ack,
    input  logic          eoi,
    output logic          irq_out,
    output logic [2:0]    irq_kind,
    output logic [VW-1:0] irq_vector,
    output logic          core_started,
    output logic [VW-1:0] irr_top,
    output logic [VW-1:0] isr_top,
    output logic          irr_top_level,
    output logic [VW-1:0] task_pri
);

    sel_e                           sel;
    logic [NUM_SPECIAL-1:0]         pend;
    logic [NUM_SPECIAL-1:0][VW-1:0] pend_vec;
    logic                           reg_ok;
    logic                           commit;
    logic                           regular_req;
    logic                           any_unmask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            task_pri <= '0;
        end else if (tpr_we) begin
            task_pri <= tpr_wdata;
        end
    end

    assign regular_req = req_valid &&
                         ((req_mode == DM_FIXED) || (req_mode == DM_LOWEST));
    assign commit      = ack && (sel != SEL_NONE);

    vipa_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_en        (regular_req),
        .set_vec       (req_vector),
        .set_level     (req_level),
        .take_en       (commit && (sel == SEL_REG)),
        .eoi_en        (eoi),
        .irr_top       (irr_top),
        .isr_top       (isr_top),
        .irr_top_level (irr_top_level)
    );

    vipa_special #(.VW(VW)) u_special (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_mode     (req_mode),
        .req_vector   (req_vector),
        .commit       (commit),
        .commit_sel   (sel),
        .pend         (pend),
        .pend_vec     (pend_vec),
        .core_started (core_started)
    );

    assign any_unmask = |pend[3:0];
    assign reg_ok     = intr_enable && (irr_top > isr_top) &&
                        (irr_top[VW-1 -: CW] > task_pri[VW-1 -: CW]);

    // Selection: unmaskable kinds in fixed order, then external, then regular.
    always_comb begin
        if (any_unmask) begin
            if (pend[0])      sel = SEL_SMI;
            else if (pend[1]) sel = SEL_NMI;
            else if (pend[2]) sel = SEL_INIT;
            else              sel = SEL_START;
        end else if (intr_enable && pend[4]) begin
            sel = SEL_EXT;
        end else if (reg_ok) begin
            sel = SEL_REG;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        irq_out    = 1'b1;
        irq_kind   = sel;
        irq_vector = '0;
        unique case (sel)
            SEL_SMI:   irq_vector = pend_vec[0];
            SEL_NMI:   irq_vector = pend_vec[1];
            SEL_INIT:  irq_vector = pend_vec[2];
            SEL_START: irq_vector = pend_vec[3];
            SEL_EXT:   irq_vector = pend_vec[4];
            SEL_REG:   irq_vector = irr_top;
            default:   irq_out    = 1'b0;
        endcase
    end

endmodule

// File: rtl/vipa_arbiter_chk.sv
module vipa_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [7:0] req_vector,
    input logic [2:0] req_mode,
    input logic       req_level,
    input logic       intr_enable,
    input logic       tpr_we,
    input logic [7:0] tpr_wdata,
    input logic       ack,
    input logic       eoi,
    input logic       irq_out,
    input logic [2:0] irq_kind,
    input logic [7:0] irq_vector,
    input logic       core_started,
    input logic [7:0] irr_top,
    input logic [7:0] isr_top,
    input logic       irr_top_level,
    input logic [7:0] task_pri
);

    assert_reg_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && irq_kind == 3'd6) |->
            (intr_enable && irr_top > isr_top && irr_top[7:4] > task_pri[7:4]));

    assert_masked_kinds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !intr_enable) |-> (irq_kind >= 3'd1 && irq_kind <= 3'd4));

    assert_ack_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eoi && irq_out && irq_kind == 3'd6) |=> (isr_top == $past(irq_vector)));

    assert_eoi_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && isr_top != 8'd0) |=> (isr_top < $past(isr_top)));

    assert_start_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && irq_kind == 3'd4) |=> core_started);

    assert_init_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && irq_kind == 3'd3) |=> !core_started);

    assert_tpr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_we |=> (task_pri == $past(tpr_wdata)));

    assert_reg_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && irq_kind == 3'd6) |-> (irq_vector != 8'd0));

endmodule

bind vipa_arbiter vipa_arbiter_chk u_chk (.*);

// File: tb/vipa_arbiter_tb.sv
module vipa_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vector = 8'd0;
    logic [2:0] req_mode = 3'd0;
    logic       req_level = 1'b0;
    logic       intr_enable = 1'b0;
    logic       tpr_we = 1'b0;
    logic [7:0] tpr_wdata = 8'd0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq_out;
    logic [2:0] irq_kind;
    logic [7:0] irq_vector;
    logic       core_started;
    logic [7:0] irr_top;
    logic [7:0] isr_top;
    logic       irr_top_level;
    logic [7:0] task_pri;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    localparam int K_NONE = 0, K_SMI = 1, K_NMI = 2, K_INIT = 3, K_START = 4, K_EXT = 5, K_REG = 6;
    localparam logic [2:0] M_FIX = 3'd0, M_LOW = 3'd1, M_SMI = 3'd2, M_RSV = 3'd3,
                           M_NMI = 3'd4, M_INIT = 3'd5, M_START = 3'd6, M_EXT = 3'd7;

    always #5 clk = ~clk;

    vipa_arbiter u_dut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0; ack = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [2:0] m, input logic [7:0] v, input logic lvl);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_vector = v; req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic do_eoi();
        @(negedge clk);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic write_tpr(input logic [7:0] d);
        @(negedge clk);
        tpr_we = 1'b1; tpr_wdata = d;
        @(negedge clk);
        tpr_we = 1'b0;
    endtask

    initial begin
        do_reset();
        chk("R11 reset irq_out", irq_out, 0);
        chk("R11 reset irq_kind", irq_kind, K_NONE);
        chk("R11 reset irr_top", irr_top, 0);
        chk("R11 reset isr_top", isr_top, 0);
        chk("R10 reset task_pri", task_pri, 0);
        chk("R4 reset core_started", core_started, 0);

        // Sweep every vector with enable set and task priority 0.
        intr_enable = 1'b1;
        for (int v = 0; v < 256; v++) begin
            send((v % 2 == 0) ? M_FIX : M_LOW, 8'(v), v[0]);
            if (v == 0) begin
                chk("R11 vector 0 is none", irr_top, 0);
                chk("R11 vector 0 not presented", irq_out, 0);
            end else begin
                chk("R1 irr_top", irr_top, v);
                chk("R1 trigger bit", irr_top_level, v % 2);
                chk("R7 class gate", irq_out, (v >= 16) ? 1 : 0);
                if (v >= 16) begin
                    chk("R7 vector", irq_vector, v);
                    do_ack();
                    chk("R8 isr_top after ack", isr_top, v);
                    chk("R8 irr_top after ack", irr_top, 15);
                    chk("R8 no irq after ack", irq_out, 0);
                    do_eoi();
                    chk("R9 isr_top after eoi", isr_top, 0);
                end
            end
        end

        // Task-priority class against vector class.
        for (int tc = 0; tc < 16; tc++) begin
            for (int vc = 1; vc < 16; vc++) begin
                do_reset();
                intr_enable = 1'b1;
                write_tpr(8'(tc * 16 + 7));
                chk("R10 task_pri", task_pri, tc * 16 + 7);
                send(M_FIX, 8'(vc * 16 + 3), 1'b0);
                chk("R7 tpr gate", irq_out, (vc > tc) ? 1 : 0);
            end
        end

        // Unmaskable ordering with enable low.
        do_reset();
        intr_enable = 1'b0;
        send(M_START, 8'h11, 1'b0);
        send(M_INIT, 8'h22, 1'b0);
        send(M_NMI, 8'h33, 1'b0);
        send(M_SMI, 8'h44, 1'b0);
        send(M_NMI, 8'h55, 1'b0);
        chk("R6 smi first", irq_kind, K_SMI);
        chk("R6 smi vector", irq_vector, 8'h44);
        chk("R6 irq with enable low", irq_out, 1);
        do_ack();
        chk("R6 nmi second", irq_kind, K_NMI);
        chk("R3 first nmi vector kept", irq_vector, 8'h33);
        do_ack();
        chk("R6 init third", irq_kind, K_INIT);
        chk("R3 init vector", irq_vector, 8'h22);
        do_ack();
        chk("R4 halted after init", core_started, 0);
        chk("R6 startup fourth", irq_kind, K_START);
        chk("R4 startup vector", irq_vector, 8'h11);
        do_ack();
        chk("R4 running after startup", core_started, 1);
        chk("R6 none left", irq_out, 0);
        send(M_START, 8'h66, 1'b0);
        chk("R4 startup ignored while running", irq_out, 0);
        send(M_INIT, 8'h77, 1'b0);
        do_ack();
        chk("R4 init halts", core_started, 0);
        send(M_START, 8'h68, 1'b0);
        send(M_START, 8'h69, 1'b0);
        chk("R4 startup accepted", irq_kind, K_START);
        chk("R4 first startup vector", irq_vector, 8'h68);
        do_ack();
        chk("R4 started again", core_started, 1);
        chk("R4 repeat startup dropped", irq_out, 0);

        // External, reserved, repeated regular, nesting and EOI.
        do_reset();
        intr_enable = 1'b0;
        send(M_RSV, 8'h90, 1'b0);
        chk("R5 reserved ignored irq", irq_out, 0);
        chk("R5 reserved ignored irr", irr_top, 0);
        send(M_EXT, 8'h9a, 1'b0);
        chk("R5 external masked", irq_out, 0);
        send(M_FIX, 8'hc0, 1'b1);
        chk("R7 regular masked", irq_out, 0);
        @(negedge clk);
        intr_enable = 1'b1;
        @(negedge clk);
        chk("R5 external kind", irq_kind, K_EXT);
        chk("R5 external vector", irq_vector, 8'h9a);
        do_ack();
        chk("R6 regular after external", irq_kind, K_REG);
        chk("R7 regular vector", irq_vector, 8'hc0);
        send(M_FIX, 8'hc0, 1'b0);
        chk("R2 trigger bit kept", irr_top_level, 1);
        chk("R2 irr_top kept", irr_top, 8'hc0);
        do_ack();
        chk("R8 isr c0", isr_top, 8'hc0);
        send(M_LOW, 8'hb0, 1'b0);
        chk("R7 below in-service", irq_out, 0);
        send(M_FIX, 8'hd0, 1'b1);
        chk("R7 above in-service", irq_vector, 8'hd0);
        do_ack();
        chk("R8 isr d0", isr_top, 8'hd0);
        chk("R8 irr_top b0", irr_top, 8'hb0);
        do_eoi();
        chk("R9 nested eoi", isr_top, 8'hc0);
        chk("R7 b0 still blocked", irq_out, 0);
        do_eoi();
        chk("R9 last eoi", isr_top, 0);
        chk("R7 b0 now presented", irq_vector, 8'hb0);
        @(negedge clk);
        intr_enable = 1'b0;
        do_ack();
        chk("R8 ack ignored irr", irr_top, 8'hb0);
        chk("R8 ack ignored isr", isr_top, 0);
        do_eoi();
        chk("R9 eoi with empty isr", isr_top, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule